// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a small load/store RISC core. Each cycle it accepts two register operands, a 16-bit immediate, a 5-bit shift count and a 5-bit operation code. One clock edge later it presents a 32-bit result. It covers wrapping add and subtract, the bitwise logic operations, three shifts and four less-than compares. Decode, the register file, memory access, branching and overflow trapping stay outside the block.

The immediate forms widen the 16-bit field in a way that depends on the operation. The arithmetic forms and the signed compare sign-extend it. The logic forms and the unsigned compare zero-extend it. There is no complement operation: software gets one by NOR-ing a register with itself. Any code outside the defined set yields zero.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` becomes zero on that edge. This takes priority over any operation presented in the same cycle.
- R2: Code 0 (add) gives rs+rt and code 1 (subtract) gives rs-rt, both modulo 2^32 with no overflow indication. The result appears on `res_o` one rising edge after the inputs are sampled.
- R3: Code 2 gives rs plus the sign-extended immediate (bit 15 copied into bits 31..16). Code 3 gives rs minus the sign-extended immediate. Both wrap modulo 2^32.
- R4: Codes 8, 9 and 10 give rs AND, OR and XOR with the zero-extended immediate (bits 31..16 are zero).
- R5: Codes 4, 5, 6 and 7 give rs AND, OR, XOR and NOR rt. NOR with rt equal to rs yields the bitwise complement of rs.
- R6: Code 11 shifts rs left and code 12 shifts rs right by `shamt_i` bit positions. Vacated positions are filled with zeros.
- R7: Code 13 shifts rs right by `shamt_i` bit positions and copies bit 31 of rs into every vacated position.
- R8: Code 14 gives 1 when rs < rt as two's-complement numbers and 0 otherwise. Code 15 makes the same test on unsigned values. Bits 31..1 of the result are zero.
- R9: Code 16 gives 1 when rs is less than the sign-extended immediate, comparing signed values. Code 17 gives 1 when rs is less than the zero-extended immediate, comparing unsigned values. Otherwise both give 0.
- R10: Codes 18 through 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_i | input | 5 | Operation code |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field, widened according to the operation |
| shamt_i | input | 5 | Shift count |
| res_o | output | 32 | Registered result |

## Verification
Reset and a valid operation can arrive in the same cycle. Reset must win, so the operation's result must never reach the output register. The bench provokes this by holding `rst` high while it presents an add whose result would be nonzero. It then expects `res_o` to read zero after that edge. The next vector, applied without reset, must produce its full result, which shows the register was cleared and not stuck.

// File: rtl/exu_pkg.sv
`timescale 1ns/1ps
package exu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_ADDI  = 5'd2,
    OP_SUBI  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_ANDI  = 5'd8,
    OP_ORI   = 5'd9,
    OP_XORI  = 5'd10,
    OP_SLL   = 5'd11,
    OP_SRL   = 5'd12,
    OP_SRA   = 5'd13,
    OP_SLT   = 5'd14,
    OP_SLTU  = 5'd15,
    OP_SLTI  = 5'd16,
    OP_SLTIU = 5'd17
  } exu_op_e;

  localparam int LAST_OP = 17;
endpackage

// File: rtl/exu_imm_ext.sv
`timescale 1ns/1ps
module exu_imm_ext
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  exu_op_e            op_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic [DATA_W-1:0]  imm_x_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic sext;

  // Arithmetic immediates and the signed compare widen with the sign bit.
  always_comb begin
    sext = (op_i == OP_ADDI) || (op_i == OP_SUBI) || (op_i == OP_SLTI);
  end

  assign imm_x_o = {{EXT_W{sext & imm_i[IMM_W-1]}}, imm_i};
endmodule

// File: rtl/exu_rshift.sv
`timescale 1ns/1ps
module exu_rshift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = val_i;

  // Logarithmic right shifter: stage k moves by 2**k when amt_i[k] is set.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill_i}}, stage[k][DATA_W-1:STEP]}
                                 : stage[k];
  end

  assign res_o = stage[SH_W];
endmodule

// File: rtl/exu_cmp.sv
`timescale 1ns/1ps
module exu_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  output logic              lt_o
);
  always_comb begin
    if (signed_i) lt_o = $signed(a_i) < $signed(b_i);
    else          lt_o = a_i < b_i;
  end
endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  exu_op_e           op;
  logic [DATA_W-1:0] imm_x;
  logic [DATA_W-1:0] opb;
  logic              use_imm;
  logic              is_sub;
  logic              cmp_signed;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;
  logic [DATA_W-1:0] sar;
  logic              lt;
  logic [DATA_W-1:0] nxt;

  assign op = exu_op_e'(op_i);

  exu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .op_i    (op),
    .imm_i   (imm_i),
    .imm_x_o (imm_x)
  );

  always_comb begin
    use_imm    = op inside {OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI,
                            OP_SLTI, OP_SLTIU};
    is_sub     = op inside {OP_SUB, OP_SUBI};
    cmp_signed = op inside {OP_SLT, OP_SLTI};
    opb        = use_imm ? imm_x : rt_i;
  end

  // One adder serves add and subtract; subtract inverts and adds one.
  assign sum = rs_i + (is_sub ? ~opb : opb) + DATA_W'(is_sub);
  assign shl = rs_i << shamt_i;

  exu_rshift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_srl (
    .val_i  (rs_i),
    .amt_i  (shamt_i),
    .fill_i (1'b0),
    .res_o  (shr)
  );

  exu_rshift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_sra (
    .val_i  (rs_i),
    .amt_i  (shamt_i),
    .fill_i (rs_i[DATA_W-1]),
    .res_o  (sar)
  );

  exu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i      (rs_i),
    .b_i      (opb),
    .signed_i (cmp_signed),
    .lt_o     (lt)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDI, OP_SUB, OP_SUBI:    nxt = sum;
      OP_AND, OP_ANDI:                     nxt = rs_i & opb;
      OP_OR, OP_ORI:                       nxt = rs_i | opb;
      OP_XOR, OP_XORI:                     nxt = rs_i ^ opb;
      OP_NOR:                              nxt = ~(rs_i | opb);
      OP_SLL:                              nxt = shl;
      OP_SRL:                              nxt = shr;
      OP_SRA:                              nxt = sar;
      OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU:  nxt = {{(DATA_W-1){1'b0}}, lt};
      default:                             nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= nxt;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> res_o == '0);

  // R2
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ADD) |-> (res_o - $past(rt_i)) == $past(rs_i));

  // R3
  subi_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SUBI) |->
      (res_o + {{EXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i)}) == $past(rs_i));

  // R4
  andi_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ANDI) |-> res_o[DATA_W-1:IMM_W] == '0);

  // R7
  sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SRA) |-> res_o[DATA_W-1] == $past(rs_i[DATA_W-1]));

  // R8
  cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= OP_SLT && $past(op_i) <= OP_SLTIU) |->
      res_o[DATA_W-1:1] == '0);

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && int'($past(op_i)) > LAST_OP) |-> res_o == '0);
endmodule

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] res_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  int_exec_unit u0 (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .imm_i   (imm_i),
    .shamt_i (shamt_i),
    .res_o   (res_o)
  );

  localparam logic [31:0] FLIP = 32'h8000_0000;

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b,
                                        logic [15:0] im, logic [4:0] sh);
    logic [31:0] se = im[15] ? (32'hFFFF_0000 | {16'h0, im}) : {16'h0, im};
    logic [31:0] ze = {16'h0, im};
    case (op)
      0:  return a + b;
      1:  return a - b;
      2:  return a + se;
      3:  return a - se;
      4:  return a & b;
      5:  return a | b;
      6:  return a ^ b;
      7:  return ~(a | b);
      8:  return a & ze;
      9:  return a | ze;
      10: return a ^ ze;
      11: return a << sh;
      12: return a >> sh;
      13: return a[31] ? ~((~a) >> sh) : (a >> sh);
      14: return {31'b0, (a ^ FLIP) < (b ^ FLIP)};
      15: return {31'b0, a < b};
      16: return {31'b0, (a ^ FLIP) < (se ^ FLIP)};
      17: return {31'b0, a < ze};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(int op);
    if (op <= 1)  return "R2";
    if (op <= 3)  return "R3";
    if (op <= 7)  return "R5";
    if (op <= 10) return "R4";
    if (op <= 12) return "R6";
    if (op == 13) return "R7";
    if (op <= 15) return "R8";
    if (op <= 17) return "R9";
    return "R10";
  endfunction

  task automatic check(logic [31:0] exp, string req, int op);
    checks++;
    if (res_o !== exp) begin
      fails++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, res_o, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im, logic [4:0] sh);
    @(negedge clk);
    op_i = 5'(op); rs_i = a; rt_i = b; imm_i = im; shamt_i = sh;
    @(posedge clk);
    #1;
    check(model(op, a, b, im, sh), req_of(op), op);
  endtask

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                            32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_8000, 32'h0000_7FFF};
  logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    check(32'h0, "R1", -1);
    // R1: reset and an add in the same cycle, reset wins
    op_i = 5'd0; rs_i = 32'd5; rt_i = 32'd9;
    @(posedge clk); #1;
    check(32'h0, "R1", 0);
    @(negedge clk);
    rst = 1'b0;
    // After release the same add must go through (R2)
    @(posedge clk); #1;
    check(32'd14, "R2", 0);

    // Sweep every code against corner operand pairs
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(op, vals[i], vals[j], imms[(i + j) % 6], 5'((i * 5 + j * 3) % 32));

    // R6, R7: every shift count on several values
    for (int op = 11; op <= 13; op++)
      for (int s = 0; s < 32; s++)
        for (int i = 2; i < 6; i++)
          apply(op, vals[i], 32'h0, 16'h0, 5'(s));

    // R3, R4, R9: immediate sweep around the sign bit
    for (int op = 2; op <= 17; op++)
      if (op == 2 || op == 3 || op == 8 || op == 9 || op == 10 || op == 16 || op == 17)
        for (int k = 0; k < 64; k++)
          apply(op, 32'hFFFF_7FF0 + 32'(k), 32'h0, 16'(16'h7FE0 + k * 1024), 5'd0);

    // R5: NOR of a register with itself is its complement
    apply(7, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 16'h0, 5'd0);
    check(32'h5A5A_F0F0, "R5", 7);
    // R2: wrap without overflow indication
    apply(0, 32'hFFFF_FFFF, 32'h2, 16'h0, 5'd0);
    check(32'h1, "R2", 0);
    // R10: unused codes yield zero
    apply(31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31);
    check(32'h0, "R10", 31);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule